// File: doc/BRIEF.md
# Bridge Overcurrent Limit and Shutdown Latch

This block sits between the current comparators of a four-switch H-bridge and the gate drive logic. It handles two tiers of overcurrent. A soft trip on one switch inhibits only that switch for a fixed number of clock cycles. When that count runs out, the switch is released again with no outside action. A hard trip on any switch sets a latch that inhibits every switch. The latch holds until the enable input is taken low.

Each rising edge of enable opens a startup window whose length in cycles is taken from `mask_len` at that edge. Inside the window, soft trips are ignored so that a motor can draw its inrush current. Hard trips are still honoured. The window opens once per enable assertion, so enable must be cycled to open it again. When enable is low, all internal state is cleared and trip inputs have no effect. The analog comparators and the ramp that sets the startup delay sit outside this block.

Top module: `bridge_trip_ctrl`

## Requirements
- R1: After reset, and while enable stays low, `sw_inhibit`, `fault_latched` and `limiting_active` are all 0.
- R2: A soft trip sampled on switch i at a clock edge sets bit i of `sw_inhibit` (bit i maps to `lim_trip[i]`) from that edge for exactly OFF_CYCLES cycles. It then clears by itself, and the other bits are not affected.
- R3: A soft trip on a switch whose off-time is running is ignored. It neither restarts nor extends that off-time.
- R4: `limiting_active` is 1 exactly while at least one switch is in its off-time.
- R5: A hard trip on any bit of `prot_trip`, sampled while enable is high, sets `fault_latched` and drives all `sw_inhibit` bits to 1 from the next edge. Both hold while enable stays high, whatever the trip inputs do.
- R6: Enable sampled low clears the latch and every off-time at that edge.
- R7: When enable rises, the clock edge that samples it high and the next `mask_len` edges ignore soft trips. A `mask_len` of 0 gives no window.
- R8: A hard trip inside the startup window still sets the latch.
- R9: The window opens only on a rising edge of enable. While enable stays high, soft trips after the window are accepted at once.
- R10: If a soft trip and a hard trip are sampled together, the latch wins and no off-time starts (`limiting_active` stays 0).
- R11: While enable is low, soft and hard trips have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Bridge enable; low clears all state |
| mask_len | input | MASK_W | Startup window length in cycles, taken at the rising edge of enable |
| lim_trip | input | NSW | Per-switch soft (limit) trip flags |
| prot_trip | input | NSW | Per-switch hard (protect) trip flags |
| sw_inhibit | output | NSW | Per-switch gate inhibit |
| fault_latched | output | 1 | Hard-trip latch state |
| limiting_active | output | 1 | At least one switch is in its off-time |

## Verification
The hardest cases to reach are the two window boundaries. One is the last masked edge and the first accepting edge after enable rises. The other is the edge where an off-time ends while a repeat trip is pending. The stimulus holds a soft trip high continuously through a rising edge of enable, with a small `mask_len`, so the first cycle the inhibit appears pins down the exact window length. A second trip is injected three cycles into a running off-time, on the same switch and on a neighbour at once. This shows that the first off-time ends on schedule while the neighbour starts its own.

// File: rtl/bridge_trip_pkg.sv
package bridge_trip_pkg;

    typedef enum logic [0:0] {
        LATCH_OPEN = 1'b0,
        LATCH_SET  = 1'b1
    } latch_e;

    // Width able to hold the value maxval.
    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/trip_mask_timer.sv
module trip_mask_timer #(
    parameter int unsigned MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MASK_W-1:0] mask_len,
    output logic              en_seen,
    output logic              mask_on
);

    typedef struct packed {
        logic              en;
        logic              on;
        logic [MASK_W-1:0] cnt;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = enable;
        if (!enable) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.en) begin
            // rising edge of enable: open the window once
            st_d.on  = (mask_len != '0);
            st_d.cnt = mask_len;
        end else if (st_q.on) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == MASK_W'(1)) begin
                st_d.on = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_seen = st_q.en;
    assign mask_on = st_q.on;

    assert_mask_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !st_q.on);

    assert_mask_onset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.on) |-> ($past(enable) && !$past(st_q.en)));

    assert_mask_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on && enable) |=> (st_q.on == ($past(st_q.cnt) != MASK_W'(1))));

endmodule

// File: rtl/trip_offtime_slot.sv
module trip_offtime_slot #(
    parameter int unsigned OFF_CYCLES = 375,
    parameter int unsigned CW         = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kill,
    output logic busy
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;   // trips ignored while counting
        end else if (arm) begin
            st_d.cnt = CW'(OFF_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

    assert_offtime_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt != '0) && !kill) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

    assert_offtime_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt == '0) && arm && !kill) |=> (st_q.cnt == CW'(OFF_CYCLES)));

endmodule

// File: rtl/bridge_trip_ctrl.sv
module bridge_trip_ctrl
    import bridge_trip_pkg::*;
#(
    parameter int unsigned NSW        = 4,
    parameter int unsigned OFF_CYCLES = 375,
    parameter int unsigned MASK_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MASK_W-1:0] mask_len,
    input  logic [NSW-1:0]    lim_trip,
    input  logic [NSW-1:0]    prot_trip,
    output logic [NSW-1:0]    sw_inhibit,
    output logic              fault_latched,
    output logic              limiting_active
);

    localparam int unsigned CW = cnt_width(OFF_CYCLES);

    typedef struct packed {
        latch_e latch;
    } top_st_t;

    top_st_t st_d, st_q;

    logic           en_seen;
    logic           mask_on;
    logic           hard_hit;
    logic           kill_all;
    logic           accept_ok;
    logic [NSW-1:0] busy;

    trip_mask_timer #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .mask_len (mask_len),
        .en_seen  (en_seen),
        .mask_on  (mask_on)
    );

    assign hard_hit  = enable && (|prot_trip);
    assign kill_all  = !enable || hard_hit || (st_q.latch == LATCH_SET);
    assign accept_ok = enable && en_seen && !mask_on;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.latch = LATCH_OPEN;
        end else if (hard_hit) begin
            st_d.latch = LATCH_SET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= LATCH_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSW; g++) begin : g_slot
        trip_offtime_slot #(.OFF_CYCLES(OFF_CYCLES), .CW(CW)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (accept_ok && lim_trip[g]),
            .kill  (kill_all),
            .busy  (busy[g])
        );
    end

    assign fault_latched   = (st_q.latch == LATCH_SET);
    assign sw_inhibit      = busy | {NSW{fault_latched}};
    assign limiting_active = |busy;

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && enable) |=> fault_latched);

    assert_enable_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!fault_latched && !limiting_active));

    assert_hard_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (|prot_trip)) |=> fault_latched);

    assert_hard_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (|prot_trip)) |=> !limiting_active);

    assert_window_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_on |=> !$rose(limiting_active));

endmodule

// File: tb/bridge_trip_ctrl_tb.sv
module bridge_trip_ctrl_tb;

    localparam int NSW = 4;
    localparam int OFF = 6;
    localparam int MW  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0;
    logic [MW-1:0]  mask_len = '0;
    logic [NSW-1:0] lim_trip = '0;
    logic [NSW-1:0] prot_trip = '0;
    logic [NSW-1:0] sw_inhibit;
    logic           fault_latched;
    logic           limiting_active;

    always #4 clk = ~clk;   // 125 MHz

    bridge_trip_ctrl #(.NSW(NSW), .OFF_CYCLES(OFF), .MASK_W(MW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable          (enable),
        .mask_len        (mask_len),
        .lim_trip        (lim_trip),
        .prot_trip       (prot_trip),
        .sw_inhibit      (sw_inhibit),
        .fault_latched   (fault_latched),
        .limiting_active (limiting_active)
    );

    typedef struct {
        int             stamp;
        logic [NSW-1:0] inh;
        logic           flt;
        logic           lact;
        string          tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(input string tag, input logic [NSW-1:0] ai, ei,
                           input logic af, ef, al, el);
        n_cmp++;
        if (ai !== ei || af !== ef || al !== el) begin
            n_bad++;
            $display("FAIL %s: inhibit=%b fault=%b limiting=%b, expected inhibit=%b fault=%b limiting=%b",
                     tag, ai, af, al, ei, ef, el);
        end
    endtask

    // monitor: pops items whose cycle has come
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].stamp == cyc) begin
            exp_t it;
            it = sb.pop_front();
            compare(it.tag, sw_inhibit, it.inh, fault_latched, it.flt, limiting_active, it.lact);
        end
    end

    // driver: applies one cycle of inputs and queues the outputs expected after the next edge
    task automatic tick(input logic en, input logic [NSW-1:0] lim, prot,
                        input logic [NSW-1:0] e_inh, input logic e_flt, e_lact,
                        input string tag);
        @(negedge clk);
        enable    = en;
        lim_trip  = lim;
        prot_trip = prot;
        sb.push_back('{cyc + 1, e_inh, e_flt, e_lact, tag});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset state", sw_inhibit, '0, fault_latched, 1'b0, limiting_active, 1'b0);
        rst_n = 1'b1;

        // R1/R11: idle with enable low
        tick(1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R1 idle");
        // enable rises with mask_len 0: R7 zero-length window
        tick(1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R7 enable edge");
        tick(1'b1, 4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b1, "R2 R7 immediate accept");
        // R2/R3/R4: retrigger on sw0 ignored, sw2 starts its own off-time
        for (int j = 1; j <= 9; j++) begin
            logic [NSW-1:0] l;
            logic [NSW-1:0] e;
            l = (j == 3) ? 4'b0101 : 4'b0000;
            e = 4'b0000;
            e[0] = (j < OFF);
            e[2] = (j >= 3) && (j - 3 < OFF);
            tick(1'b1, l, 4'b0000, e, 1'b0, |e, "R2 R3 R4 off-time");
        end
        // R9: enable still high, no new window, trip accepted at once
        tick(1'b1, 4'b0010, 4'b0000, 4'b0010, 1'b0, 1'b1, "R9 no re-window");
        for (int j = 1; j <= 6; j++) begin
            logic s;
            s = (j < OFF);
            tick(1'b1, 4'b0000, 4'b0000, {2'b00, s, 1'b0}, 1'b0, s, "R2 self release");
        end
        // R10 then R5 hold
        tick(1'b1, 4'b0001, 4'b0100, 4'b1111, 1'b1, 1'b0, "R10 hard wins");
        for (int j = 0; j < 3; j++)
            tick(1'b1, 4'b1111, 4'b0000, 4'b1111, 1'b1, 1'b0, "R5 latch hold");
        // R6 clear, R11 trips ignored while low
        tick(1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R6 enable low clears");
        tick(1'b0, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, "R11 trips ignored");
        tick(1'b0, 4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b0, "R11 trips ignored");

        // R7: window of 4 cycles with the soft trip held high
        mask_len = MW'(4);
        for (int j = 1; j <= 5; j++)
            tick(1'b1, 4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, "R7 masked");
        tick(1'b1, 4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b1, "R7 first accept");
        tick(1'b1, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b1, "R4 limiting");
        tick(1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R6 off-time cleared");
        // R9: recycling enable re-opens the window
        for (int j = 1; j <= 5; j++)
            tick(1'b1, 4'b1000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R9 re-window");
        tick(1'b1, 4'b1000, 4'b0000, 4'b1000, 1'b0, 1'b1, "R9 re-window end");
        tick(1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R6 clear");
        // R8: hard trip inside the window
        tick(1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R8 enable edge");
        tick(1'b1, 4'b0000, 4'b0010, 4'b1111, 1'b1, 1'b0, "R8 hard in window");
        tick(1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, "R6 latch released");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items left unchecked", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule